// File: doc/BRIEF.md
# Trap Entry and Delegation Unit

This unit takes a trap request from a processor pipeline and performs the hardware side of trap entry. A request carries an interrupt flag, a cause code and the faulting address; alongside it the pipeline presents the program counter of the trapping instruction, the current privilege level and the current status word. The unit chooses whether the trap is taken at supervisor or machine level, using the exception delegation mask for exceptions and the interrupt delegation mask for interrupts.

On the clock edge where a request is valid, the unit produces the redirect PC from the matching trap vector in direct mode, with its low two bits forced to zero. It loads the cause, exception PC and trap-value registers of the chosen level, writes the updated status word and sets the new privilege. Environment calls are recorded with the cause of the level they came from. A trap value is kept only for misaligned, access-fault and page-fault causes.

The control is a three-state machine. `ST_RUN` means no trap was entered on the last edge. `ST_SUPER_ENTRY` means a trap was entered at supervisor level on the last edge. `ST_MACH_ENTRY` means a trap was entered at machine level on the last edge. On every edge the machine goes to `ST_SUPER_ENTRY` if a valid request is routed to supervisor level, to `ST_MACH_ENTRY` if a valid request is routed to machine level, and to `ST_RUN` when no request is valid. The trap-taken pulse is high in both entry states.

Top module: `trap_entry_unit`

## Requirements
- R1: Every cycle with `trap_valid_i` high is followed by exactly one cycle with `trap_taken_o` high, and every register update for that trap becomes visible on that same edge. `trap_taken_o` is low after a cycle with no request.
- R2: A trap goes to supervisor level only when `priv_i` is 0 (user) or 1 (supervisor) and the delegation bit is set. Otherwise it goes to machine level, and that includes privilege code 2. Exceptions take the bit from `medeleg_i` and interrupts take it from `mideleg_i`. The bit index is the 5-bit `trap_code_i`.
- R3: The cause recorded for an interrupt has bit XLEN-1 set, `trap_code_i` in bits 4:0 and zeros in between.
- R4: An exception with code 8 (environment call) is recorded as 8 plus `priv_i`: 8 from user, 9 from supervisor, 11 from machine. Every other exception code is recorded unchanged.
- R5: The trap value equals `trap_addr_i` for exception codes 0, 1, 4, 5, 6, 7, 12, 13 and 15. It is zero for every other exception code and for every interrupt.
- R6: On a supervisor entry the unit does all of the following: `pc_next_o` = `stvec_i` with bits 1:0 cleared; `scause_o`, `sepc_o` (= `pc_i`) and `stval_o` are loaded; `priv_o` = 1. In the status word, bit 5 takes old bit 1, bit 8 takes `priv_i[0]` and bit 1 is cleared. All three machine-level registers keep their values.
- R7: On a machine entry the unit does all of the following: `pc_next_o` = `mtvec_i` with bits 1:0 cleared; `mcause_o`, `mepc_o` (= `pc_i`) and `mtval_o` are loaded; `priv_o` = 3. In the status word, bit 7 takes old bit 3, bits 12:11 take `priv_i` and bit 3 is cleared. All three supervisor-level registers keep their values.
- R8: On any trap entry, every status bit not named in R6 or R7 is copied from `status_i` into `status_o`.
- R9: After reset, `priv_o` is 3, `trap_taken_o` is 0, and `pc_next_o`, `status_o` and all six cause, exception-PC and trap-value registers are zero.
- R10: In a cycle without a request, `pc_next_o`, `priv_o`, `status_o` and all six trap registers keep their values, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trap_valid_i | input | 1 | A trap request is present this cycle |
| trap_irq_i | input | 1 | 1 = interrupt, 0 = exception |
| trap_code_i | input | 5 | Interrupt number or exception code |
| trap_addr_i | input | XLEN | Faulting address for the trap value |
| pc_i | input | XLEN | PC of the trapping instruction |
| priv_i | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| status_i | input | XLEN | Current status word |
| medeleg_i | input | XLEN | Exception delegation mask |
| mideleg_i | input | XLEN | Interrupt delegation mask |
| stvec_i | input | XLEN | Supervisor trap vector |
| mtvec_i | input | XLEN | Machine trap vector |
| trap_taken_o | output | 1 | One-cycle pulse after a trap entry |
| pc_next_o | output | XLEN | Redirect PC of the last trap |
| priv_o | output | 2 | Privilege after the last trap |
| status_o | output | XLEN | Status word after the last trap |
| scause_o | output | XLEN | Supervisor cause register |
| sepc_o | output | XLEN | Supervisor exception PC |
| stval_o | output | XLEN | Supervisor trap value |
| mcause_o | output | XLEN | Machine cause register |
| mepc_o | output | XLEN | Machine exception PC |
| mtval_o | output | XLEN | Machine trap value |

## Verification
The bench builds the unit with XLEN = 32. At that width the interrupt flag sits at bit 31, and a 5-bit code can address every bit of the 32-bit delegation masks, so random masks cover delegation of every possible cause. Randomly chosen privileges include the reserved code 2, and random vectors include values with their low bits set. Together these reach the route to machine level from every privilege, the clearing of the vector low bits and every branch of the environment-call remap.

// File: rtl/trap_pkg.sv
package trap_pkg;
    localparam int CODE_W = 5;

    typedef enum logic [1:0] {
        PRIV_U   = 2'b00,
        PRIV_S   = 2'b01,
        PRIV_RSV = 2'b10,
        PRIV_M   = 2'b11
    } priv_e;

    typedef enum logic [1:0] {
        ST_RUN         = 2'b00,
        ST_SUPER_ENTRY = 2'b01,
        ST_MACH_ENTRY  = 2'b10
    } entry_e;

    // status word bit positions (decoded by software)
    localparam int ST_SIE  = 1;
    localparam int ST_MIE  = 3;
    localparam int ST_SPIE = 5;
    localparam int ST_MPIE = 7;
    localparam int ST_SPP  = 8;
    localparam int ST_MPP  = 11;

    localparam logic [CODE_W-1:0] EC_ENV_CALL = 5'd8;
endpackage

// File: rtl/trap_cause_fix.sv
module trap_cause_fix
    import trap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              irq_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [1:0]        priv_i,
    input  logic [XLEN-1:0]   addr_i,
    output logic [XLEN-1:0]   cause_o,
    output logic [XLEN-1:0]   tval_o
);
    localparam int PAD_W = XLEN - 1 - CODE_W;

    logic keeps_addr;

    always_comb begin
        unique case (code_i)
            5'd0, 5'd1, 5'd4, 5'd5, 5'd6, 5'd7, 5'd12, 5'd13, 5'd15: keeps_addr = 1'b1;
            default: keeps_addr = 1'b0;
        endcase
    end

    always_comb begin
        if (irq_i) begin
            cause_o = {1'b1, {PAD_W{1'b0}}, code_i};
        end else if (code_i == EC_ENV_CALL) begin
            cause_o = XLEN'(code_i) + XLEN'(priv_i);
        end else begin
            cause_o = XLEN'(code_i);
        end
        tval_o = (!irq_i && keeps_addr) ? addr_i : '0;
    end
endmodule

// File: rtl/trap_route.sv
module trap_route
    import trap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              irq_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [1:0]        priv_i,
    input  logic [XLEN-1:0]   medeleg_i,
    input  logic [XLEN-1:0]   mideleg_i,
    output logic              to_super_o
);
    logic [XLEN-1:0] mask;
    logic            low_priv;

    always_comb begin
        mask       = irq_i ? mideleg_i : medeleg_i;
        low_priv   = (priv_i == PRIV_U) || (priv_i == PRIV_S);
        to_super_o = low_priv && mask[code_i];
    end
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
    import trap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_valid_i,
    input  logic              trap_irq_i,
    input  logic [4:0]        trap_code_i,
    input  logic [XLEN-1:0]   trap_addr_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [1:0]        priv_i,
    input  logic [XLEN-1:0]   status_i,
    input  logic [XLEN-1:0]   medeleg_i,
    input  logic [XLEN-1:0]   mideleg_i,
    input  logic [XLEN-1:0]   stvec_i,
    input  logic [XLEN-1:0]   mtvec_i,
    output logic              trap_taken_o,
    output logic [XLEN-1:0]   pc_next_o,
    output logic [1:0]        priv_o,
    output logic [XLEN-1:0]   status_o,
    output logic [XLEN-1:0]   scause_o,
    output logic [XLEN-1:0]   sepc_o,
    output logic [XLEN-1:0]   stval_o,
    output logic [XLEN-1:0]   mcause_o,
    output logic [XLEN-1:0]   mepc_o,
    output logic [XLEN-1:0]   mtval_o
);
    entry_e          state_q, state_d;
    logic            to_super;
    logic [XLEN-1:0] cause, tval;
    logic [XLEN-1:0] st_super, st_mach;

    trap_cause_fix #(.XLEN(XLEN)) u_cause (
        .irq_i  (trap_irq_i),
        .code_i (trap_code_i),
        .priv_i (priv_i),
        .addr_i (trap_addr_i),
        .cause_o(cause),
        .tval_o (tval)
    );

    trap_route #(.XLEN(XLEN)) u_route (
        .irq_i     (trap_irq_i),
        .code_i    (trap_code_i),
        .priv_i    (priv_i),
        .medeleg_i (medeleg_i),
        .mideleg_i (mideleg_i),
        .to_super_o(to_super)
    );

    // status words written on entry at each level
    always_comb begin
        st_super          = status_i;
        st_super[ST_SPIE] = status_i[ST_SIE];
        st_super[ST_SPP]  = priv_i[0];
        st_super[ST_SIE]  = 1'b0;
        st_mach                 = status_i;
        st_mach[ST_MPIE]        = status_i[ST_MIE];
        st_mach[ST_MPP+1:ST_MPP] = priv_i;
        st_mach[ST_MIE]         = 1'b0;
    end

    always_comb begin
        if (!trap_valid_i)  state_d = ST_RUN;
        else if (to_super)  state_d = ST_SUPER_ENTRY;
        else                state_d = ST_MACH_ENTRY;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    assign trap_taken_o = (state_q != ST_RUN);

    // architectural outputs, written per decided entry
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_next_o <= '0;
            priv_o    <= PRIV_M;
            status_o  <= '0;
            scause_o  <= '0;
            sepc_o    <= '0;
            stval_o   <= '0;
            mcause_o  <= '0;
            mepc_o    <= '0;
            mtval_o   <= '0;
        end else begin
            unique case (state_d)
                ST_SUPER_ENTRY: begin
                    pc_next_o <= {stvec_i[XLEN-1:2], 2'b00};
                    priv_o    <= PRIV_S;
                    status_o  <= st_super;
                    scause_o  <= cause;
                    sepc_o    <= pc_i;
                    stval_o   <= tval;
                end
                ST_MACH_ENTRY: begin
                    pc_next_o <= {mtvec_i[XLEN-1:2], 2'b00};
                    priv_o    <= PRIV_M;
                    status_o  <= st_mach;
                    mcause_o  <= cause;
                    mepc_o    <= pc_i;
                    mtval_o   <= tval;
                end
                default: ;
            endcase
        end
    end

    // R1: each request gives a pulse on the next cycle, no request none
    p_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid_i |=> trap_taken_o);
    p_no_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_valid_i |=> !trap_taken_o);
    // R2: a trap raised from machine privilege stays at machine level
    p_mach_stays_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid_i && priv_i == PRIV_M) |=> (priv_o == PRIV_M));
    // R6: supervisor entry leaves machine bank untouched, clears SIE
    p_super_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_taken_o && priv_o == PRIV_S) |-> ($stable(mcause_o) && $stable(mepc_o) && !status_o[ST_SIE]));
    // R7: machine entry leaves supervisor bank untouched, clears MIE
    p_mach_bank_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_taken_o && priv_o == PRIV_M) |-> ($stable(scause_o) && $stable(sepc_o) && !status_o[ST_MIE]));
    // R6/R7: direct-mode vector is word aligned
    p_vec_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken_o |-> (pc_next_o[1:0] == 2'b00));
    // R10: nothing changes without a request
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_valid_i |=> ($stable(pc_next_o) && $stable(priv_o) && $stable(status_o) && $stable(stval_o) && $stable(mtval_o)));
endmodule

// File: tb/trap_entry_unit_tb_top.sv
module trap_entry_unit_tb_top;
    localparam int XLEN = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trap_valid_i = 1'b0, trap_irq_i = 1'b0;
    logic [4:0] trap_code_i = '0;
    logic [1:0] priv_i = '0;
    logic [XLEN-1:0] trap_addr_i = '0, pc_i = '0, status_i = '0;
    logic [XLEN-1:0] medeleg_i = '0, mideleg_i = '0, stvec_i = '0, mtvec_i = '0;
    logic trap_taken_o;
    logic [1:0] priv_o;
    logic [XLEN-1:0] pc_next_o, status_o, scause_o, sepc_o, stval_o, mcause_o, mepc_o, mtval_o;

    always #2.5 clk = ~clk;

    trap_entry_unit #(.XLEN(XLEN)) dut_i (.*);

    int total = 0, bad = 0;
    bit done = 0;

    // expected state
    logic e_taken = 0;
    logic [1:0] e_priv = 2'd3;
    logic [XLEN-1:0] e_pc = 0, e_st = 0, e_sc = 0, e_se = 0, e_sv = 0, e_mc = 0, e_me = 0, e_mv = 0;

    function automatic logic [XLEN-1:0] f_cause(logic irq, logic [4:0] code, logic [1:0] p);
        if (irq) return 32'h8000_0000 | 32'(code);
        if (code == 5'd8) return 32'd8 + 32'(p);
        return 32'(code);
    endfunction

    function automatic logic [XLEN-1:0] f_tval(logic irq, logic [4:0] code, logic [XLEN-1:0] a);
        if (irq) return '0;
        if (code inside {5'd0, 5'd1, 5'd4, 5'd5, 5'd6, 5'd7, 5'd12, 5'd13, 5'd15}) return a;
        return '0;
    endfunction

    task automatic chk(string tag, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all();
        chk("R1 trap_taken", 32'(trap_taken_o), 32'(e_taken));
        chk("R6/R7 pc_next", pc_next_o, e_pc);
        chk("R2 priv", 32'(priv_o), 32'(e_priv));
        chk("R6/R7/R8 status", status_o, e_st);
        chk("R3/R4 scause", scause_o, e_sc);
        chk("R6 sepc", sepc_o, e_se);
        chk("R5 stval", stval_o, e_sv);
        chk("R3/R4 mcause", mcause_o, e_mc);
        chk("R7 mepc", mepc_o, e_me);
        chk("R5 mtval", mtval_o, e_mv);
    endtask

    // drive one cycle (at negedge) and update the model, then check at next negedge
    task automatic step(logic v, logic irq, logic [4:0] code, logic [1:0] p, logic [XLEN-1:0] st,
                        logic [XLEN-1:0] md, logic [XLEN-1:0] mi, logic [XLEN-1:0] sv,
                        logic [XLEN-1:0] mv, logic [XLEN-1:0] pc, logic [XLEN-1:0] a);
        logic sup;
        logic [XLEN-1:0] s;
        trap_valid_i = v; trap_irq_i = irq; trap_code_i = code; priv_i = p; status_i = st;
        medeleg_i = md; mideleg_i = mi; stvec_i = sv; mtvec_i = mv; pc_i = pc; trap_addr_i = a;
        e_taken = v;
        if (v) begin
            sup = (p <= 2'd1) && (irq ? mi[code] : md[code]);
            s = st;
            if (sup) begin
                s[5] = st[1]; s[8] = p[0]; s[1] = 1'b0;
                e_pc = sv & ~32'h3; e_priv = 2'd1; e_st = s;
                e_sc = f_cause(irq, code, p); e_se = pc; e_sv = f_tval(irq, code, a);
            end else begin
                s[7] = st[3]; s[12:11] = p; s[3] = 1'b0;
                e_pc = mv & ~32'h3; e_priv = 2'd3; e_st = s;
                e_mc = f_cause(irq, code, p); e_me = pc; e_mv = f_tval(irq, code, a);
            end
        end
        @(negedge clk);
        check_all();
    endtask

    function automatic logic [XLEN-1:0] rnd();
        return $urandom();
    endfunction

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all(); // R9 reset state
        // R10: random inputs with no request leave everything held
        repeat (5) step(0, 1, 5'd3, 2'd0, rnd(), rnd(), rnd(), rnd(), rnd(), rnd(), rnd());
        // R4: environment call from each privilege, all delegated
        step(1, 0, 5'd8, 2'd0, 32'h0000_0002, '1, '0, 32'h1003, 32'h2003, 32'h100, 32'hDEAD);
        step(1, 0, 5'd8, 2'd1, 32'h0000_0000, '1, '0, 32'h1003, 32'h2003, 32'h104, 32'hDEAD);
        step(1, 0, 5'd8, 2'd3, 32'h0000_0008, '1, '0, 32'h1003, 32'h2003, 32'h108, 32'hDEAD);
        // R2: reserved privilege code 2 never delegates
        step(1, 0, 5'd13, 2'd2, 32'hFFFF_FFFF, '1, '1, 32'h1000, 32'h2001, 32'h10C, 32'hBEEF);
        // R3: interrupt delegated from user, then same interrupt undelegated
        step(1, 1, 5'd9, 2'd0, 32'h0000_0002, '0, 32'h200, 32'h3002, 32'h4000, 32'h110, 32'hAAAA);
        step(1, 1, 5'd9, 2'd0, 32'h0000_0008, 32'h200, '0, 32'h3002, 32'h4000, 32'h114, 32'hAAAA);
        // R2: interrupt bit 31 index, exception mask ignored for interrupts
        step(1, 1, 5'd31, 2'd1, '0, 32'h8000_0000, 32'h8000_0000, 32'h5000, 32'h6000, 32'h118, 32'h1);
        // R5: fault with address vs. non-fault code
        step(1, 0, 5'd15, 2'd3, '0, '0, '0, 0, 32'h7000, 32'h11C, 32'h1234_5678);
        step(1, 0, 5'd2, 2'd3, '0, '0, '0, 0, 32'h7000, 32'h120, 32'h1234_5678);
        step(0, 0, 5'd0, 2'd0, rnd(), rnd(), rnd(), rnd(), rnd(), rnd(), rnd());
        // random mix covering R1, R2, R5, R6, R7, R8
        for (int i = 0; i < 600; i++) begin
            logic [4:0] code;
            logic irq;
            irq = ($urandom_range(0, 3) == 0);
            code = ($urandom_range(0, 4) == 0) ? 5'd8 : 5'($urandom_range(0, irq ? 31 : 16));
            step($urandom_range(0, 4) != 0, irq, code, 2'($urandom_range(0, 3)), rnd(),
                 rnd(), rnd(), rnd(), rnd(), rnd(), rnd());
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=hung expected=finished");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule